// File: doc/BRIEF.md
# Triangular Decimation-Free Filter for One-Bit Streams

This block takes a one-bit oversampled audio stream, qualified by a bit enable, and turns each accepted bit into a signed multibit sample. The block reads bit value 1 as +1 and bit value 0 as -1. It filters these levels with a symmetric 15-tap triangular impulse response. The result feeds a downstream remodulator at the same rate. No multipliers are used. The triangle is built from two cascaded 8-sample running sums, and each sum updates incrementally: add the newest value and drop the oldest. The block supports rates from 64 to 512 times 44.1 kHz or 48 kHz, provided the master clock runs at least as fast as the bit enable.

When the filter select is low, the block passes the raw input bit straight through. It re-registers the bit on the master clock, and the filter keeps its state frozen. After reset, the delay lines hold a pattern that alternates between 1 and 0. Such a pattern stands for silence, so the output starts at zero and does not jump.

Top module: `tri_fir_dsd`

## Requirements
- R1: Bit value 1 enters the filter as +1 and bit value 0 enters as -1. A steady run of ones therefore settles at +64, and a steady run of zeros settles at -64.
- R2: Each accepted bit produces an output equal to the sum of the 15 most recent levels, newest first, weighted 1,2,3,4,5,6,7,8,7,6,5,4,3,2,1.
- R3: The output never leaves the range -64..+64, and both limits can be reached.
- R4: `sample_valid` is high for exactly the one clock after each edge where `bit_en` and `filter_en` are both high. `sample_out` changes only on such edges and holds its value otherwise.
- R5: Reset clears `sample_out`, `sample_valid` and `pass_bit` to 0. Reset also loads the history as an alternating stream in which the bit just before the first post-reset bit is 0, the one before that is 1, and so on back in time.
- R6: While `filter_en` is low, `pass_bit` equals the value `bit_in` had one clock earlier on every clock, whatever `bit_en` does. In that time `sample_valid` stays low and `sample_out` holds.
- R7: While `filter_en` is high, `pass_bit` is 0 one clock later.
- R8: Bits that arrive while `filter_en` is low do not enter the filter. After filtering resumes, the outputs match a stream that never contained those bits.
- R9: Idle clocks between enabled bits, of any length, leave the results unchanged. Only enabled bits advance the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | One-bit stream data |
| bit_en | input | 1 | Qualifies `bit_in` for one clock |
| filter_en | input | 1 | 1 = filter the stream, 0 = resynchronized pass-through |
| sample_out | output | OUT_W | Signed filtered sample |
| sample_valid | output | 1 | One-clock strobe for a new `sample_out` |
| pass_bit | output | 1 | Re-registered input bit in pass-through mode |

## Verification
The bench builds the block with its defaults, HALF_LEN = 8 and OUT_W = 8. This gives exactly 15 taps, and the peak magnitude of 64 lies inside the 8-bit signed output word. Runs of 15 identical bits are therefore enough to drive the output to both +64 and -64. The whole response, from the alternating reset history through steady state, comes within reach of short directed stimulus. The bench model keeps a 15-entry history of levels and applies the explicit triangular weights. The RTL uses two running sums instead, so the bench reaches the same numbers by a different route.

// File: rtl/tri_fir_pkg.sv
package tri_fir_pkg;

  // Level of a stream bit: 1 -> +1, 0 -> -1 (R1)
  function automatic logic signed [1:0] bit_level(input logic b);
    return b ? 2'sd1 : -2'sd1;
  endfunction

  // Silence history: j samples before the newest slot; even j holds -1
  function automatic logic signed [1:0] silence_level(input int j);
    return (j % 2 == 1) ? 2'sd1 : -2'sd1;
  endfunction

  // Minimum signed width to hold +/-mag
  function automatic int signed_width(input int mag);
    return $clog2(mag + 1) + 1;
  endfunction

endpackage

// File: rtl/tri_boxcar.sv
module tri_boxcar
  import tri_fir_pkg::*;
#(
  parameter int LEN     = 8,
  parameter int IN_MAX  = 1,
  parameter int IN_W    = 2,
  parameter int SUM_W   = 5,
  parameter bit ALT_RST = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [SUM_W-1:0] sum_q,
  output logic signed [SUM_W-1:0] sum_nx
);
  localparam int SUM_MAX = LEN * IN_MAX;

  logic signed [IN_W-1:0] hist [LEN];
  logic signed [IN_W-1:0] oldest;

  function automatic logic signed [IN_W-1:0] rst_val(input int j);
    if (ALT_RST) return IN_W'(silence_level(j));
    else         return '0;
  endfunction

  for (genvar j = 0; j < LEN; j++) begin : g_tap
    if (j == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hist[j] <= rst_val(j);
        else if (en) hist[j] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hist[j] <= rst_val(j);
        else if (en) hist[j] <= hist[j-1];
      end
    end
  end

  assign oldest = hist[LEN-1];
  assign sum_nx = sum_q + SUM_W'(din) - SUM_W'(oldest);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sum_q <= '0;
    else if (en) sum_q <= sum_nx;
  end

  // R3: a running sum of LEN bounded inputs stays bounded
  a_r3_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q <= SUM_W'(SUM_MAX)) && (sum_q >= -SUM_W'(SUM_MAX)));

  // R3: the incoming value respects its declared bound
  a_r3_din_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((din <= IN_W'(IN_MAX)) && (din >= -IN_W'(IN_MAX))));

  // R9: an idle clock leaves the running sum untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(sum_q));

endmodule

// File: rtl/tri_bypass.sv
module tri_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic route_raw,
  input  logic bit_in,
  output logic pass_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_bit <= 1'b0;
    else        pass_bit <= route_raw & bit_in;
  end

  // R6: pass-through mirrors the previous clock's input bit
  a_r6_resync: assert property (@(posedge clk) disable iff (!rst_n)
    route_raw |=> (pass_bit == $past(bit_in)));

  // R7: pass-through output is quiet in filter mode
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !route_raw |=> !pass_bit);

endmodule

// File: rtl/tri_fir_dsd.sv
module tri_fir_dsd
  import tri_fir_pkg::*;
#(
  parameter int HALF_LEN = 8,
  parameter int OUT_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_in,
  input  logic                    bit_en,
  input  logic                    filter_en,
  output logic signed [OUT_W-1:0] sample_out,
  output logic                    sample_valid,
  output logic                    pass_bit
);
  localparam int TAPS  = 2 * HALF_LEN - 1;
  localparam int PEAK  = HALF_LEN * HALF_LEN;
  localparam int S1_W  = signed_width(HALF_LEN);
  localparam int S2_W  = signed_width(PEAK);

  logic                   accept;
  logic signed [1:0]      level;
  logic signed [S1_W-1:0] s1_q, s1_nx;
  logic signed [S2_W-1:0] s2_q, s2_nx;

  assign accept = bit_en & filter_en;
  assign level  = bit_level(bit_in);

  // First running sum over the +/-1 levels; history reset to silence
  tri_boxcar #(
    .LEN(HALF_LEN), .IN_MAX(1), .IN_W(2), .SUM_W(S1_W), .ALT_RST(1'b1)
  ) u_stage1 (
    .clk(clk), .rst_n(rst_n), .en(accept), .din(level),
    .sum_q(s1_q), .sum_nx(s1_nx)
  );

  // Second running sum over the first; together a TAPS-long triangle
  tri_boxcar #(
    .LEN(HALF_LEN), .IN_MAX(HALF_LEN), .IN_W(S1_W), .SUM_W(S2_W), .ALT_RST(1'b0)
  ) u_stage2 (
    .clk(clk), .rst_n(rst_n), .en(accept), .din(s1_nx),
    .sum_q(s2_q), .sum_nx(s2_nx)
  );

  tri_bypass u_bypass (
    .clk(clk), .rst_n(rst_n), .route_raw(!filter_en),
    .bit_in(bit_in), .pass_bit(pass_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_valid <= 1'b0;
    else        sample_valid <= accept;
  end

  assign sample_out = OUT_W'(s2_q);

  // R4: each accepted bit yields a strobe one clock later
  a_r4_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sample_valid);

  // R4 / R6: no strobe without an accepted bit
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !sample_valid);

  // R4 / R8: the sample holds between accepted bits
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(sample_out));

  // R3: output within the triangle's peak
  a_r3_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out <= OUT_W'(PEAK)) && (sample_out >= -OUT_W'(PEAK)));

  // R2: tap count consistent with the cascade
  initial begin
    a_r2_taps: assert (TAPS == 2 * HALF_LEN - 1 && OUT_W >= S2_W);
  end

endmodule

// File: tb/tb_tri_fir_dsd.sv
module tb_tri_fir_dsd;
  localparam int HALF = 8;
  localparam int NT   = 2 * HALF - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              bit_in = 1'b0;
  logic              bit_en = 1'b0;
  logic              filter_en = 1'b1;
  logic signed [7:0] sample_out;
  logic              sample_valid;
  logic              pass_bit;

  tri_fir_dsd #(.HALF_LEN(HALF), .OUT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
    .filter_en(filter_en), .sample_out(sample_out),
    .sample_valid(sample_valid), .pass_bit(pass_bit)
  );

  int checks = 0;
  int fails  = 0;
  int hist [NT];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int weight(input int k);
    return (k < HALF) ? k + 1 : NT - k;
  endfunction

  function automatic int model_out();
    int s = 0;
    for (int k = 0; k < NT; k++) s += weight(k) * hist[k];
    return s;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < NT; k++) hist[k] = (k % 2 == 0) ? -1 : 1;
  endtask

  task automatic model_push(input logic b);
    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = b ? 1 : -1;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // One accepted bit; result checked one clock later (R2, R4, R7)
  task automatic push(input logic b, input string tag);
    @(negedge clk);
    bit_in = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    model_push(b);
    chk({tag, " R4 strobe"}, int'(sample_valid), 1);
    chk(tag, int'(sample_out), model_out());
    chk({tag, " R7 pass quiet"}, int'(pass_bit), 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; filter_en = 1'b1;
    idle(3);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R5 sample_out", int'(sample_out), 0);
    chk("R5 sample_valid", int'(sample_valid), 0);
    chk("R5 pass_bit", int'(pass_bit), 0);
    push(1'b1, "R5 first bit against silence history");
    push(1'b1, "R5 second bit");
  endtask

  task automatic t_steady();
    do_reset();
    for (int i = 0; i < 20; i++) push(1'b1, "R1 ones run");
    chk("R3 positive peak", int'(sample_out), 64);
    for (int i = 0; i < 20; i++) push(1'b0, "R1 zeros run");
    chk("R3 negative peak", int'(sample_out), -64);
  endtask

  task automatic t_impulse();
    do_reset();
    for (int i = 0; i < 20; i++) push(1'b0, "R2 settle low");
    push(1'b1, "R2 impulse");
    for (int i = 0; i < 16; i++) push(1'b0, "R2 impulse tail");
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 200; i++) begin
      step_lfsr();
      push(lfsr[0], "R2 random stream");
      idle(int'(lfsr[3:1]) % 5);
    end
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 12; i++) begin
      push(i[0] ^ i[2], "R9 sparse enables");
      idle(i * 3);
    end
  endtask

  task automatic t_bypass();
    int held;
    logic prev;
    do_reset();
    for (int i = 0; i < 10; i++) push(i[1], "R8 prefill");
    held = int'(sample_out);
    prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R6 pass_bit follows", int'(pass_bit), int'(prev));
        chk("R6 no strobe", int'(sample_valid), 0);
        chk("R6 sample held", int'(sample_out), held);
      end
      filter_en = 1'b0;
      step_lfsr();
      bit_in = lfsr[0];
      bit_en = lfsr[1];
      prev   = lfsr[0];
    end
    @(negedge clk);
    filter_en = 1'b1; bit_en = 1'b0; bit_in = 1'b1;
    @(negedge clk);
    chk("R7 pass_bit after return", int'(pass_bit), 0);
    chk("R8 sample unchanged", int'(sample_out), held);
    for (int i = 0; i < 20; i++) push(i[0] | i[3], "R8 resume");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_steady();
    t_impulse();
    t_random();
    t_gaps();
    t_bypass();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule